// File: doc/BRIEF.md
# Two-Class Message Slot Allocator

This block keeps track of which entries of a fixed pool of message buffers are in use. It serves two kinds of requester: the receive path and the transmit path. Each request asks for one slot. The block returns the index of a slot it has just claimed, or it reports that no slot can be given. A separate port hands slots back.

The lowest quarter of the pool is kept for the receive path alone. Transmit requests search upward from index `POOL/4`, so outgoing traffic can never use up the buffers that incoming responses need. Receive requests search from index 0. In both cases the lowest free slot in the allowed range is claimed, and finding it and marking it used happen in one step. A claim and a hand-back may occur in the same cycle. Both are applied, but the slot being handed back is not offered in that cycle. The block keeps a registered count of free slots.

Top module: `slot_alloc_top`

## Requirements
- R1: Reset clears the whole pool. After reset, `free_cnt` equals `POOL`, and `gnt_valid`, `gnt_fail`, `rel_err` and `gnt_slot` are all 0.
- R2: A request sampled at a clock edge produces its result on the outputs after that edge, for one cycle. Exactly one of `gnt_valid` and `gnt_fail` is 1. Both stay 0 in any cycle that follows no request.
- R3: A receive request (`alloc_tx`=0) is granted the lowest-indexed free slot in 0..POOL-1.
- R4: A transmit request (`alloc_tx`=1) is granted the lowest-indexed free slot in POOL/4..POOL-1. It is never granted a slot below POOL/4.
- R5: A granted slot is marked used in the same step. It is never granted again until it has been released.
- R6: A request that finds no free slot in its allowed range sets `gnt_fail` and leaves `gnt_slot` at 0. It changes no slot's state. A transmit request can fail while receive-only slots are still free.
- R7: Releasing a used slot (`rel_req`=1, `rel_idx`) makes it free. A later request may then be granted that slot.
- R8: A request and a release in the same cycle are both applied. The slot being released is not granted in that cycle.
- R9: Releasing a slot that is already free pulses `rel_err` in the next cycle and changes no state.
- R10: `free_cnt` is registered and equals the number of free slots after all operations of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_req | input | 1 | Request one slot |
| alloc_tx | input | 1 | Class of the request: 0 receive, 1 transmit |
| rel_req | input | 1 | Release a slot |
| rel_idx | input | $clog2(POOL) | Index of the slot to release |
| gnt_valid | output | 1 | The request was granted |
| gnt_fail | output | 1 | The request could not be served |
| gnt_slot | output | $clog2(POOL) | Granted slot index, 0 when no slot was granted |
| rel_err | output | 1 | A release named a slot that was already free |
| free_cnt | output | $clog2(POOL+1) | Number of free slots |

## Verification
The bench fills the transmit range completely. It then checks that a transmit request fails while a receive request still gets slot 0. A design that ignored the reserved quarter would instead hand transmit slot 0 there, and the bench would flag it. With the pool full, the bench issues a release and a receive request in the same cycle. That request must fail, and the next one must get the released slot; a design that recycled the slot in the same cycle would succeed too early. The bench also releases a slot that is already free. A design without the check would miss the error pulse or would disturb `free_cnt`. Random mixes of requests and releases compare every grant index with a reference search.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;
  typedef enum logic {
    CLS_RX = 1'b0,
    CLS_TX = 1'b1
  } req_class_e;
endpackage

// File: rtl/slot_range_mask.sv
module slot_range_mask
  import slot_alloc_pkg::*;
#(
  parameter int POOL = 16
) (
  input  req_class_e       cls,
  output logic [POOL-1:0]  allow
);
  localparam int RSV = POOL / 4;

  for (genvar g = 0; g < POOL; g++) begin : g_bit
    if (g < RSV) begin : g_rsv
      assign allow[g] = (cls == CLS_RX);
    end else begin : g_shared
      assign allow[g] = 1'b1;
    end
  end
endmodule

// File: rtl/slot_first_free.sv
module slot_first_free #(
  parameter int POOL  = 16,
  parameter int IDX_W = $clog2(POOL)
) (
  input  logic [POOL-1:0]  cand,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = POOL - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = i[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/slot_used_bank.sv
module slot_used_bank #(
  parameter int POOL  = 16,
  parameter int IDX_W = $clog2(POOL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [POOL-1:0]  used_q
);
  logic [POOL-1:0] used_n;

  always_comb begin
    used_n = used_q;
    if (clr_en) used_n[clr_idx] = 1'b0;
    if (set_en) used_n[set_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) used_q <= '0;
    else     used_q <= used_n;
  end
endmodule

// File: rtl/slot_alloc_top.sv
module slot_alloc_top
  import slot_alloc_pkg::*;
#(
  parameter int POOL  = 16,
  parameter int IDX_W = $clog2(POOL),
  parameter int CNT_W = $clog2(POOL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_req,
  input  logic             alloc_tx,
  input  logic             rel_req,
  input  logic [IDX_W-1:0] rel_idx,
  output logic             gnt_valid,
  output logic             gnt_fail,
  output logic [IDX_W-1:0] gnt_slot,
  output logic             rel_err,
  output logic [CNT_W-1:0] free_cnt
);
  localparam logic [POOL-1:0] ONE_HOT0 = {{(POOL-1){1'b0}}, 1'b1};

  logic [POOL-1:0]  used_q;
  logic [POOL-1:0]  allow;
  logic [POOL-1:0]  rel_hot;
  logic [POOL-1:0]  cand;
  logic             found;
  logic [IDX_W-1:0] pick;
  logic             rel_ok;
  logic             do_grant;
  req_class_e       cls;

  assign cls      = alloc_tx ? CLS_TX : CLS_RX;
  assign rel_hot  = rel_req ? (ONE_HOT0 << rel_idx) : '0;
  assign cand     = ~used_q & allow & ~rel_hot;
  assign rel_ok   = rel_req & used_q[rel_idx];
  assign do_grant = alloc_req & found;

  slot_range_mask #(.POOL(POOL)) u_mask (
    .cls   (cls),
    .allow (allow)
  );

  slot_first_free #(.POOL(POOL), .IDX_W(IDX_W)) u_pick (
    .cand  (cand),
    .found (found),
    .idx   (pick)
  );

  slot_used_bank #(.POOL(POOL), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .set_en  (do_grant),
    .set_idx (pick),
    .clr_en  (rel_ok),
    .clr_idx (rel_idx),
    .used_q  (used_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_valid <= 1'b0;
      gnt_fail  <= 1'b0;
      gnt_slot  <= '0;
      rel_err   <= 1'b0;
      free_cnt  <= CNT_W'(POOL);
    end else begin
      gnt_valid <= do_grant;
      gnt_fail  <= alloc_req & ~found;
      gnt_slot  <= do_grant ? pick : '0;
      rel_err   <= rel_req & ~rel_ok;
      free_cnt  <= free_cnt - CNT_W'(do_grant) + CNT_W'(rel_ok);
    end
  end
endmodule

// File: rtl/slot_alloc_chk.sv
module slot_alloc_chk #(
  parameter int POOL  = 16,
  parameter int IDX_W = $clog2(POOL),
  parameter int CNT_W = $clog2(POOL + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_req,
  input logic             alloc_tx,
  input logic             rel_req,
  input logic [IDX_W-1:0] rel_idx,
  input logic             gnt_valid,
  input logic             gnt_fail,
  input logic [IDX_W-1:0] gnt_slot,
  input logic             rel_err,
  input logic [CNT_W-1:0] free_cnt,
  input logic [POOL-1:0]  used_q
);
  localparam int RSV = POOL / 4;

  logic [POOL-1:0]  prev_used;
  logic             prev_rel;
  logic [IDX_W-1:0] prev_rel_idx;
  logic             prev_req;
  logic             prev_tx;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_used    <= '0;
      prev_rel     <= 1'b0;
      prev_rel_idx <= '0;
      prev_req     <= 1'b0;
      prev_tx      <= 1'b0;
    end else begin
      prev_used    <= used_q;
      prev_rel     <= rel_req;
      prev_rel_idx <= rel_idx;
      prev_req     <= alloc_req;
      prev_tx      <= alloc_tx;
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    !(gnt_valid && gnt_fail)); // R2
  AST_RESULT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid || gnt_fail) |-> prev_req); // R2
  AST_TX_ABOVE_RSV: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && prev_tx) |-> (int'(gnt_slot) >= RSV)); // R4
  AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> (!prev_used[gnt_slot] && used_q[gnt_slot])); // R5
  AST_REL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (prev_rel && !rel_err) |-> !used_q[prev_rel_idx]); // R7
  AST_REL_NOT_REGRANTED: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && prev_rel) |-> (gnt_slot != prev_rel_idx)); // R8
  AST_ERR_KEEPS_SLOT: assert property (@(posedge clk) disable iff (rst)
    rel_err |-> (prev_used == used_q || gnt_valid)); // R9
  AST_FREE_COUNT: assert property (@(posedge clk) disable iff (rst)
    int'(free_cnt) == POOL - $countones(used_q)); // R10
endmodule

bind slot_alloc_top slot_alloc_chk #(.POOL(POOL), .IDX_W(IDX_W), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .alloc_req (alloc_req),
  .alloc_tx  (alloc_tx),
  .rel_req   (rel_req),
  .rel_idx   (rel_idx),
  .gnt_valid (gnt_valid),
  .gnt_fail  (gnt_fail),
  .gnt_slot  (gnt_slot),
  .rel_err   (rel_err),
  .free_cnt  (free_cnt),
  .used_q    (used_q)
);

// File: tb/slot_alloc_top_tb_top.sv
module slot_alloc_top_tb_top;
  localparam int POOL  = 16;
  localparam int IDX_W = $clog2(POOL);
  localparam int CNT_W = $clog2(POOL + 1);
  localparam int RSV   = POOL / 4;

  logic             clk = 1'b0;
  logic             rst;
  logic             alloc_req, alloc_tx, rel_req;
  logic [IDX_W-1:0] rel_idx;
  logic             gnt_valid, gnt_fail, rel_err;
  logic [IDX_W-1:0] gnt_slot;
  logic [CNT_W-1:0] free_cnt;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  logic [POOL-1:0] m_used;

  always #10 clk = ~clk;

  slot_alloc_top #(.POOL(POOL)) dut_i (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_tx(alloc_tx),
    .rel_req(rel_req), .rel_idx(rel_idx), .gnt_valid(gnt_valid),
    .gnt_fail(gnt_fail), .gnt_slot(gnt_slot), .rel_err(rel_err),
    .free_cnt(free_cnt)
  );

  function automatic int ref_pick(logic [POOL-1:0] used, logic tx, logic [POOL-1:0] excl);
    int lo = tx ? RSV : 0;
    for (int i = lo; i < POOL; i++)
      if (!used[i] && !excl[i]) return i;
    return -1;
  endfunction

  function automatic int ref_free(logic [POOL-1:0] used);
    int n = 0;
    for (int i = 0; i < POOL; i++) if (!used[i]) n++;
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic op(input logic a, input logic tx, input logic r, input int ridx);
    logic [POOL-1:0] excl;
    int   exp_pick;
    bit   exp_err;
    string treq;
    alloc_req = a; alloc_tx = tx; rel_req = r; rel_idx = IDX_W'(ridx);
    excl     = r ? (POOL'(1) << ridx) : '0;
    exp_pick = a ? ref_pick(m_used, tx, excl) : -1;
    exp_err  = r && !m_used[ridx];
    @(posedge clk);
    @(negedge clk);
    alloc_req = 1'b0; rel_req = 1'b0;
    treq = r ? "R8" : (tx ? "R4" : "R3");
    chk(gnt_valid == (a && exp_pick >= 0), a ? treq : "R2", int'(gnt_valid), int'(a && exp_pick >= 0));
    chk(gnt_fail == (a && exp_pick < 0), a ? "R6" : "R2", int'(gnt_fail), int'(a && exp_pick < 0));
    chk(int'(gnt_slot) == (exp_pick >= 0 ? exp_pick : 0), exp_pick >= 0 ? treq : "R6",
        int'(gnt_slot), exp_pick >= 0 ? exp_pick : 0);
    chk(rel_err == exp_err, "R9", int'(rel_err), int'(exp_err));
    if (r && !exp_err) m_used[ridx] = 1'b0;
    if (exp_pick >= 0) m_used[exp_pick] = 1'b1;
    chk(int'(free_cnt) == ref_free(m_used), exp_err ? "R9" : "R10", int'(free_cnt), ref_free(m_used));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_used = '0;
    alloc_req = 1'b0; alloc_tx = 1'b0; rel_req = 1'b0; rel_idx = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(free_cnt == CNT_W'(POOL), "R1", int'(free_cnt), POOL);
    chk(!gnt_valid && !gnt_fail && !rel_err && gnt_slot == '0, "R1",
        int'({gnt_valid, gnt_fail, rel_err}), 0);
    op(0, 0, 0, 0);
    // R4/R5: fill transmit range, slots RSV..POOL-1
    for (int k = RSV; k < POOL; k++) op(1, 1, 0, 0);
    // R6: transmit fails while receive slots remain
    op(1, 1, 0, 0);
    // R3: receive takes slot 0
    op(1, 0, 0, 0);
    for (int k = 1; k < RSV; k++) op(1, 0, 0, 0);
    // R6: receive fails on full pool
    op(1, 0, 0, 0);
    // R8: release slot 2 and request together: must fail
    op(1, 0, 1, 2);
    // R7: next request gets slot 2
    op(1, 0, 0, 0);
    // R9: release of a free slot
    op(0, 0, 1, 9);
    op(0, 0, 1, 9);
    op(0, 0, 1, 9);
    // R7/R8 random mix
    for (int n = 0; n < 3000; n++) begin
      logic a, t, r;
      a = ($urandom % 3) != 0;
      t = $urandom % 2;
      r = ($urandom % 2) != 0;
      op(a, t, r, int'($urandom % POOL));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule